// File: doc/BRIEF.md
# Hit-Skipping Channel Scanner and Serial Word Emitter

This block walks a fixed ring of detector channels in step with a free-running analogue multiplexer, spending exactly one sample period on each channel. At every sample boundary it captures, for the channel under the multiplexer, whether that channel is to be read out, whether it was a true hit or only a neighbour of one, and its rise-time and timestamp codes. Channels not marked for readout are passed over without producing anything, and the scan never pauses or compacts.

The converter result for a sample arrives a fixed number of sample periods after the multiplexer presented that channel. The captured channel information is held back by the same number of periods, so every output word joins a converter result with the metadata of the sample that produced it. That word is shifted out MSB first, one bit per clock, with a valid strobe. A sample period lasts as many clocks as the word has bits. Consecutive readout words therefore follow each other with no gap and no queue.

Top module: `readout_scanner`

## Requirements
- R1: While reset is held, `dv_o` and `ser_o` are 0, `mux_ch_o` is 0 and `sample_o` is 1.
- R2: `sample_o` is high for one clock out of every WORD_W (34) clocks, starting with the first clock after reset.
- R3: `mux_ch_o` advances by one at the end of every `sample_o` clock, whatever the flags, and steps from NUM_CH-1 (99) back to 0.
- R4: A sample whose channel was not flagged produces a 34-clock slot with `dv_o` low and `ser_o` low throughout.
- R5: The channel inputs sampled at sample boundary k, with `flag_i` high, yield a word whose first bit appears on the clock after boundary k+ADC_LAT (ADC_LAT=2). The word is sent MSB first over 34 clocks as bits [33:27] channel, [26] hit, [25:19] rise time, [18:12] timestamp, [11:0] converter result.
- R6: The converter field is `adc_i` as sampled at boundary k+ADC_LAT; the other fields are those captured at boundary k.
- R7: When two successive samples are both flagged, `dv_o` stays high without a break across both words.
- R8: The hit bit in the word equals `hit_i` at capture, independently of `flag_i`, so a neighbour readout (flag 1, hit 0) is emitted with hit 0.
- R9: `dv_o` changes only on the clock edge that ends a `sample_o` clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flag_i | input | 1 | Current channel is to be read out |
| hit_i | input | 1 | Current channel crossed the energy threshold |
| rise_i | input | 7 | Rise-time code of current channel |
| ts_i | input | 7 | Timestamp code of current channel |
| adc_i | input | 12 | Converter result, valid on `sample_o` clocks |
| sample_o | output | 1 | Sample boundary strobe |
| mux_ch_o | output | 7 | Channel currently selected by the multiplexer |
| ser_o | output | 1 | Serial data, MSB first |
| dv_o | output | 1 | Serial data valid |

## Verification
The sharpest coincidence is at a sample boundary: on that one clock the last bit of the previous word is still on `ser_o` while the next word is loaded and the channel counter advances, possibly wrapping from 99 to 0. Runs of consecutive flagged channels, one of them straddling the wrap, provoke it. The bench captures all 34 bits and all 34 valid levels of every slot, including the boundary clock, and compares them with words it builds itself from the stimulus history, so a lost final bit, a break in valid or a misaligned converter field shows up as a word mismatch.

// File: rtl/scan_pkg.sv
package scan_pkg;

   // Serial word width from its field widths (channel, hit bit, rise, stamp, converter).
   function automatic int unsigned word_bits(input int unsigned ch_w, input int unsigned rt_w,
                                             input int unsigned ts_w, input int unsigned adc_w);
      return ch_w + 1 + rt_w + ts_w + adc_w;
   endfunction

   // Counter width able to hold values 0..n-1, at least one bit.
   function automatic int unsigned cnt_bits(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/scan_seq.sv
module scan_seq #(
   parameter int unsigned NUM_CH = 100,
   parameter int unsigned CH_W   = 7,
   parameter int unsigned WORD_W = 34
) (
   input  logic            clk,
   input  logic            rst_n,
   output logic            strobe_o,
   output logic [CH_W-1:0] ch_o
);
   localparam int unsigned     PH_W    = scan_pkg::cnt_bits(WORD_W);
   localparam logic [PH_W-1:0] PH_LAST = PH_W'(WORD_W - 1);
   localparam logic [CH_W-1:0] CH_LAST = CH_W'(NUM_CH - 1);

   logic [PH_W-1:0] phase_q;
   logic [CH_W-1:0] ch_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= '0;
         ch_q    <= '0;
      end else begin
         if (phase_q == PH_LAST) phase_q <= '0;
         else                    phase_q <= phase_q + PH_W'(1);
         if (phase_q == '0) begin
            if (ch_q == CH_LAST) ch_q <= '0;
            else                 ch_q <= ch_q + CH_W'(1);
         end
      end
   end

   assign strobe_o = (phase_q == '0);
   assign ch_o     = ch_q;

   // R3: channel wraps from the last to zero
   p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_o && ch_o == CH_LAST) |=> (ch_o == '0));

   // R3: channel only moves at a boundary
   p_hold_ch_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe_o |=> $stable(ch_o));

   p_phase_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      phase_q <= PH_LAST);

   generate
      if (WORD_W > 1) begin : g_gap_chk
         p_strobe_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
            strobe_o |=> !strobe_o);
      end
   endgenerate
endmodule

// File: rtl/meta_delay.sv
module meta_delay #(
   parameter int unsigned META_W = 23,
   parameter int unsigned LAT    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv_i,
   input  logic [META_W-1:0] meta_i,
   output logic [META_W-1:0] meta_o
);
   generate
      if (LAT == 0) begin : g_direct
         assign meta_o = meta_i;
      end else begin : g_pipe
         logic [META_W-1:0] st_q [LAT];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < int'(LAT); i++) st_q[i] <= '0;
            end else if (adv_i) begin
               st_q[0] <= meta_i;
               for (int i = 1; i < int'(LAT); i++) st_q[i] <= st_q[i-1];
            end
         end

         assign meta_o = st_q[LAT-1];

         // R6: the aged entry only moves at a boundary
         p_age_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !adv_i |=> $stable(meta_o));
      end
   endgenerate
endmodule

// File: rtl/word_shifter.sv
module word_shifter #(
   parameter int unsigned WORD_W = 34
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              valid_i,
   input  logic [WORD_W-1:0] word_i,
   output logic              ser_o,
   output logic              dv_o
);
   logic [WORD_W-1:0] sh_q;
   logic              dv_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q <= '0;
         dv_q <= 1'b0;
      end else if (load_i) begin
         sh_q <= valid_i ? word_i : '0;
         dv_q <= valid_i;
      end else begin
         sh_q <= {sh_q[WORD_W-2:0], 1'b0};
      end
   end

   assign ser_o = sh_q[WORD_W-1];
   assign dv_o  = dv_q;

   // R9: valid moves only where a slot starts
   p_dv_slot_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> $stable(dv_o));

   // R4: line is quiet in an empty slot
   p_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !dv_o |-> !ser_o);
endmodule

// File: rtl/readout_scanner.sv
module readout_scanner #(
   parameter int unsigned NUM_CH  = 100,
   parameter int unsigned CH_W    = 7,
   parameter int unsigned RT_W    = 7,
   parameter int unsigned TS_W    = 7,
   parameter int unsigned ADC_W   = 12,
   parameter int unsigned ADC_LAT = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flag_i,
   input  logic             hit_i,
   input  logic [RT_W-1:0]  rise_i,
   input  logic [TS_W-1:0]  ts_i,
   input  logic [ADC_W-1:0] adc_i,
   output logic             sample_o,
   output logic [CH_W-1:0]  mux_ch_o,
   output logic             ser_o,
   output logic             dv_o
);
   localparam int unsigned WORD_W = scan_pkg::word_bits(CH_W, RT_W, TS_W, ADC_W);
   localparam int unsigned META_W = CH_W + 1 + RT_W + TS_W + 1;

   generate
      if (NUM_CH < 2 || NUM_CH > (1 << CH_W)) begin : g_bad_ch
         $error("readout_scanner: NUM_CH does not fit CH_W");
      end
      if (META_W - 1 + ADC_W != WORD_W) begin : g_bad_word
         $error("readout_scanner: field widths inconsistent");
      end
   endgenerate

   logic [META_W-1:0] meta_now;
   logic [META_W-1:0] meta_old;
   logic [WORD_W-1:0] word;

   scan_seq #(.NUM_CH(NUM_CH), .CH_W(CH_W), .WORD_W(WORD_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .strobe_o (sample_o),
      .ch_o     (mux_ch_o)
   );

   // flag sits in the LSB, the rest is the word prefix in send order
   assign meta_now = {mux_ch_o, hit_i, rise_i, ts_i, flag_i};

   meta_delay #(.META_W(META_W), .LAT(ADC_LAT)) u_dly (
      .clk    (clk),
      .rst_n  (rst_n),
      .adv_i  (sample_o),
      .meta_i (meta_now),
      .meta_o (meta_old)
   );

   assign word = {meta_old[META_W-1:1], adc_i};

   word_shifter #(.WORD_W(WORD_W)) u_shf (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (sample_o),
      .valid_i (meta_old[0]),
      .word_i  (word),
      .ser_o   (ser_o),
      .dv_o    (dv_o)
   );

   // R5: a flagged aged entry starts a word with the channel MSB
   p_emit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_o && meta_old[0]) |=> (dv_o && ser_o == $past(meta_old[META_W-1])));

   // R4: an unflagged aged entry opens an empty slot
   p_skip_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_o && !meta_old[0]) |=> !dv_o);
endmodule

// File: tb/sim_readout_scanner.sv
`timescale 1ns/1ps
module sim_readout_scanner;
   localparam int NCH = 100;
   localparam int WW  = 34;
   localparam int LAT = 2;
   localparam int NS  = 320;

   logic clk = 1'b0;
   logic rst_n;
   logic flag_i, hit_i;
   logic [6:0]  rise_i, ts_i;
   logic [11:0] adc_i;
   logic sample_o, ser_o, dv_o;
   logic [6:0] mux_ch_o;

   always #2.5 clk = ~clk;

   readout_scanner u0 (
      .clk(clk), .rst_n(rst_n), .flag_i(flag_i), .hit_i(hit_i),
      .rise_i(rise_i), .ts_i(ts_i), .adc_i(adc_i),
      .sample_o(sample_o), .mux_ch_o(mux_ch_o), .ser_o(ser_o), .dv_o(dv_o)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   bit          flag_a [NS];
   bit          hit_a  [NS];
   logic [6:0]  rise_a [NS];
   logic [6:0]  ts_a   [NS];
   logic [11:0] adc_a  [NS];

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic bit exp_dv(input int s);
      return (s >= LAT) && flag_a[s-LAT];
   endfunction

   function automatic logic [WW-1:0] exp_word(input int s);
      if (!exp_dv(s)) return '0;
      return {7'((s-LAT) % NCH), hit_a[s-LAT], rise_a[s-LAT], ts_a[s-LAT], adc_a[s]};
   endfunction

   function automatic bit directed_flag(input int s, output bit f);
      if (s < 6)                 begin f = (s != 1 && s != 4); return 1'b1; end
      if (s >= 10 && s <= 16)    begin f = 1'b1; return 1'b1; end
      if (s >= 96 && s <= 103)   begin f = 1'b1; return 1'b1; end
      if (s >= 200 && s <= 204)  begin f = 1'b0; return 1'b1; end
      return 1'b0;
   endfunction

   initial begin
      logic [WW-1:0] got;
      logic [WW-1:0] dvb;
      logic [WW-1:0] ew;
      bit f, st_ok;
      void'($urandom(32'd4711));
      for (int s = 0; s < NS; s++) begin
         if (!directed_flag(s, f)) f = ($urandom % 4) == 0;
         flag_a[s] = f;
         hit_a[s]  = (s >= 96 && s <= 103) ? s[0] : 1'($urandom);
         rise_a[s] = 7'($urandom);
         ts_a[s]   = 7'($urandom);
         adc_a[s]  = (s == 12) ? 12'hFFF : (s == 13) ? 12'h000 : 12'($urandom);
      end
      rst_n = 1'b0; flag_i = 0; hit_i = 0; rise_i = '0; ts_i = '0; adc_i = '0;
      got = '0; dvb = '0;
      repeat (4) @(negedge clk);
      chk(dv_o == 0 && ser_o == 0 && mux_ch_o == 0 && sample_o == 1, "R1 reset state",
          {dv_o, ser_o, sample_o, mux_ch_o}, {3'b001, 7'd0});
      for (int s = 0; s < NS; s++) begin
         if (s > 0) begin
            got[0] = ser_o; dvb[0] = dv_o;
            ew = exp_word(s-1);
            chk(got == ew && dvb == {WW{exp_dv(s-1)}},
                !exp_dv(s-1) ? "R4 skipped slot" :
                (exp_dv(s-2) ? "R7 back-to-back word" :
                 (hit_a[s-1-LAT] ? "R5 R6 word" : "R8 neighbour word")),
                {dvb[3:0], 26'd0, got}, {{4{exp_dv(s-1)}}, 26'd0, ew});
         end
         if (s == 0) rst_n = 1'b1;
         chk(sample_o == 1 && mux_ch_o == 7'(s % NCH), "R2 R3 boundary/channel",
             {sample_o, mux_ch_o}, {1'b1, 7'(s % NCH)});
         flag_i = flag_a[s]; hit_i = hit_a[s]; rise_i = rise_a[s]; ts_i = ts_a[s]; adc_i = adc_a[s];
         st_ok = 1'b1;
         for (int p = 1; p < WW; p++) begin
            @(negedge clk);
            if (sample_o) st_ok = 1'b0;
            got[WW-p] = ser_o; dvb[WW-p] = dv_o;
         end
         if (dvb[WW-1:1] != {(WW-1){dvb[WW-1]}}) st_ok = 1'b0;
         chk(st_ok, "R2 R9 no strobe or valid change inside slot", {63'd0, st_ok}, 64'd1);
         @(negedge clk);
      end
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog R2 actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule